// File: doc/BRIEF.md
# Port Alternate-Function Assignment Register

This block owns the control register of an 8-pin port. For each pin, the register decides whether the pin is ordinary general-purpose I/O or carries one of the system's bus control signals. The control signals are the bus clock, read/write, byte strobe, two instruction-pipe status bits and a no-access cycle indicator. Whenever a pin is claimed by its control function, the block enables that pin's driver and routes the signal to it, whatever the data-direction bit says. Pins that are not claimed take their output-enable from the data-direction register and their value from the data register.

The register's reset contents come from a 3-bit operating-mode strap, which the block samples while reset is asserted. Modes that need the external bus immediately after reset therefore start with the right signals already enabled. The same latched mode also decides whether the register is visible on the on-chip register bus. In the expanded modes and in special peripheral mode, the register is hidden. An access to its address in those modes is marked external, and it neither reads nor writes the internal register.

Top module: `pe_assign_top`

## Requirements
- R1: Mode encoding on `mode_i`: 0 special single-chip, 1 emulation narrow, 2 special test, 3 emulation wide, 4 normal single-chip, 5 normal expanded narrow, 6 special peripheral, 7 normal expanded wide. The mode is latched while `rst_ni` is low. In special single-chip and special peripheral modes, the register resets to 0x00.
- R2: In normal single-chip mode (4), the register resets to 0x10. Bus-clock output is disabled and every pin is general-purpose I/O.
- R3: In normal expanded modes (5, 7), the register resets to 0x00. Only pin 4 (bus clock) is claimed, and every other pin stays general-purpose I/O.
- R4: In special test and emulation modes (1, 2, 3), the register resets to 0x2C. This claims pins 6, 5 (pipe status bits 1 and 0), pin 4 (bus clock), pin 3 (byte strobe) and pin 2 (read/write).
- R5: Field positions are as follows. Bit 7 enables the no-access signal on pin 7. Bit 5 enables pipe status on pins 6 and 5. Bit 4 disables the bus clock on pin 4 when it is 1. Bit 3 enables byte strobe on pin 3. Bit 2 enables read/write on pin 2. A claimed pin has `oe_o` = 1 and `do_o` equal to its control signal, and the pin's `ddr_i` and `dat_i` bits have no effect.
- R6: An unclaimed pin, including pins 1 and 0 always, has `oe_o` = `ddr_i` and `do_o` = `dat_i`.
- R7: In modes 0, 2 and 4 the register is mapped. A read (`sel_i` = 1, `wr_i` = 0) returns its contents combinationally. A write is captured at the clock edge, and the new pin assignment applies from the next cycle.
- R8: In modes 1, 3, 5, 6 and 7 the register is unmapped. Any access drives `ext_o` = 1 and `rdata_o` = 0, and a write leaves the register unchanged.
- R9: A change of `mode_i` without a reset changes neither the register, the pin assignment, nor the mapping.
- R10: Bits 6, 1 and 0 are reserved. They ignore writes and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating-mode strap, sampled at reset |
| sel_i | input | 1 | Register address selected |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| ext_o | output | 1 | Access must go to the external bus |
| ddr_i | input | 8 | Data-direction register bits |
| dat_i | input | 8 | Data register bits |
| eclk_i | input | 1 | Bus clock |
| rw_i | input | 1 | Read/write signal |
| lstrb_i | input | 1 | Byte strobe |
| pipe_i | input | 2 | Instruction-pipe status |
| noacc_i | input | 1 | No-access cycle indicator |
| oe_o | output | 8 | Per-pin output enable |
| do_o | output | 8 | Per-pin output value |

## Verification
The bench resets into all eight modes and checks each reset image at the pins. It also reads the register back wherever the register is mapped, so a swapped mode decode shows up as a wrong pin claimed or a wrong readback. The active-low bus-clock bit is exercised in both polarities, which catches an inverted sense as a pin-4 driver stuck on or off. The data-direction and data inputs are randomized under every selection: a mux that let `ddr_i` leak through on a claimed pin would drop the driver. The bench writes in unmapped modes and toggles the mode strap without a reset. A design that decoded the live strap, or that failed to gate hidden writes, would then change the pin assignment.

// File: rtl/pe_assign_pkg.sv
package pe_assign_pkg;
  localparam int PORT_W = 8;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_SPC_SGL    = 3'd0,
    MODE_EMU_NARROW = 3'd1,
    MODE_SPC_TEST   = 3'd2,
    MODE_EMU_WIDE   = 3'd3,
    MODE_NRM_SGL    = 3'd4,
    MODE_NRM_NARROW = 3'd5,
    MODE_SPC_PERIPH = 3'd6,
    MODE_NRM_WIDE   = 3'd7
  } op_mode_e;

  localparam int B_NOACC = 7;
  localparam int B_PIPE  = 5;
  localparam int B_ECLKN = 4;
  localparam int B_STRB  = 3;
  localparam int B_RW    = 2;

  localparam logic [PORT_W-1:0] IMPL_MASK =
    PORT_W'((1 << B_NOACC) | (1 << B_PIPE) | (1 << B_ECLKN) | (1 << B_STRB) | (1 << B_RW));

  function automatic logic [PORT_W-1:0] reset_image(op_mode_e m);
    logic [PORT_W-1:0] v;
    v = '0;
    unique case (m)
      MODE_NRM_SGL: v[B_ECLKN] = 1'b1;
      MODE_SPC_TEST, MODE_EMU_NARROW, MODE_EMU_WIDE: begin
        v[B_PIPE] = 1'b1;
        v[B_STRB] = 1'b1;
        v[B_RW]   = 1'b1;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic is_mapped(op_mode_e m);
    return (m == MODE_SPC_SGL) || (m == MODE_SPC_TEST) || (m == MODE_NRM_SGL);
  endfunction
endpackage

// File: rtl/pe_assign_reg.sv
module pe_assign_reg
  import pe_assign_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  output logic              ext_o,
  output logic [PORT_W-1:0] cfg_o
);
  op_mode_e          mode_q;
  logic [PORT_W-1:0] cfg_q;
  logic              mapped;
  logic              wr_en;

  // strap captured while reset is held; later changes are ignored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= op_mode_e'(mode_i);
  end

  assign mapped = is_mapped(mode_q);
  assign wr_en  = sel_i && wr_i && mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= reset_image(op_mode_e'(mode_i));
    else if (wr_en) cfg_q <= wdata_i & IMPL_MASK;
  end

  assign rdata_o = (sel_i && !wr_i && mapped) ? cfg_q : '0;
  assign ext_o   = sel_i && !mapped;
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/pe_alt_map.sv
module pe_alt_map
  import pe_assign_pkg::*;
(
  input  logic [PORT_W-1:0] cfg_i,
  input  logic              eclk_i,
  input  logic              rw_i,
  input  logic              lstrb_i,
  input  logic [1:0]        pipe_i,
  input  logic              noacc_i,
  output logic [PORT_W-1:0] alt_en_o,
  output logic [PORT_W-1:0] alt_val_o
);
  always_comb begin
    alt_en_o  = '0;
    alt_val_o = '0;
    alt_en_o[7]  = cfg_i[B_NOACC];
    alt_val_o[7] = noacc_i;
    alt_en_o[6]  = cfg_i[B_PIPE];
    alt_val_o[6] = pipe_i[1];
    alt_en_o[5]  = cfg_i[B_PIPE];
    alt_val_o[5] = pipe_i[0];
    alt_en_o[4]  = ~cfg_i[B_ECLKN];
    alt_val_o[4] = eclk_i;
    alt_en_o[3]  = cfg_i[B_STRB];
    alt_val_o[3] = lstrb_i;
    alt_en_o[2]  = cfg_i[B_RW];
    alt_val_o[2] = rw_i;
  end
endmodule

// File: rtl/pe_pin_mux.sv
module pe_pin_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] alt_en_i,
  input  logic [W-1:0] alt_val_i,
  input  logic [W-1:0] ddr_i,
  input  logic [W-1:0] dat_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] do_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign oe_o[i] = alt_en_i[i] ? 1'b1         : ddr_i[i];
    assign do_o[i] = alt_en_i[i] ? alt_val_i[i] : dat_i[i];
  end
endmodule

// File: rtl/pe_assign_top.sv
module pe_assign_top
  import pe_assign_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  output logic              ext_o,
  input  logic [PORT_W-1:0] ddr_i,
  input  logic [PORT_W-1:0] dat_i,
  input  logic              eclk_i,
  input  logic              rw_i,
  input  logic              lstrb_i,
  input  logic [1:0]        pipe_i,
  input  logic              noacc_i,
  output logic [PORT_W-1:0] oe_o,
  output logic [PORT_W-1:0] do_o
);
  logic [PORT_W-1:0] cfg_q;
  logic [PORT_W-1:0] alt_en;
  logic [PORT_W-1:0] alt_val;

  pe_assign_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ext_o   (ext_o),
    .cfg_o   (cfg_q)
  );

  pe_alt_map u_map (
    .cfg_i     (cfg_q),
    .eclk_i    (eclk_i),
    .rw_i      (rw_i),
    .lstrb_i   (lstrb_i),
    .pipe_i    (pipe_i),
    .noacc_i   (noacc_i),
    .alt_en_o  (alt_en),
    .alt_val_o (alt_val)
  );

  pe_pin_mux #(.W(PORT_W)) u_mux (
    .alt_en_i  (alt_en),
    .alt_val_i (alt_val),
    .ddr_i     (ddr_i),
    .dat_i     (dat_i),
    .oe_o      (oe_o),
    .do_o      (do_o)
  );
endmodule

// File: rtl/pe_assign_chk.sv
module pe_assign_chk
  import pe_assign_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [PORT_W-1:0] wdata_i,
  input logic [PORT_W-1:0] rdata_o,
  input logic              ext_o,
  input logic [PORT_W-1:0] ddr_i,
  input logic [PORT_W-1:0] dat_i,
  input logic              eclk_i,
  input logic [PORT_W-1:0] oe_o,
  input logic [PORT_W-1:0] do_o,
  input logic [PORT_W-1:0] cfg_q
);
  AST_RSV_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~IMPL_MASK) == '0);                                      // R10
  AST_EXT_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_o |-> rdata_o == '0);                                           // R8
  AST_EXT_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_o && wr_i) |=> $stable(cfg_q));                                // R8
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && !ext_o) |=> cfg_q == ($past(wdata_i) & IMPL_MASK)); // R7
  AST_ECLK_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q[B_ECLKN] |-> (oe_o[4] && do_o[4] == eclk_i));                // R5
  AST_LOW_PINS_GPIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o[1:0] == ddr_i[1:0] && do_o[1:0] == dat_i[1:0]);                // R6
endmodule

bind pe_assign_top pe_assign_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .ext_o   (ext_o),
  .ddr_i   (ddr_i),
  .dat_i   (dat_i),
  .eclk_i  (eclk_i),
  .oe_o    (oe_o),
  .do_o    (do_o),
  .cfg_q   (cfg_q)
);

// File: tb/sim_pe_assign_top.sv
module sim_pe_assign_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic       sel_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ext_o;
  logic [7:0] ddr_i = '0;
  logic [7:0] dat_i = '0;
  logic       eclk_i = 1'b0;
  logic       rw_i = 1'b0;
  logic       lstrb_i = 1'b0;
  logic [1:0] pipe_i = '0;
  logic       noacc_i = 1'b0;
  logic [7:0] oe_o;
  logic [7:0] do_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_reg;
  logic [2:0] m_mode;

  always #2 clk_i = ~clk_i;

  pe_assign_top u0 (.*);

  function automatic logic [7:0] exp_reset(logic [2:0] m);
    case (m)
      3'd4:             return 8'h10;               // R2
      3'd1, 3'd2, 3'd3: return 8'h2C;               // R4
      default:          return 8'h00;               // R1, R3
    endcase
  endfunction

  function automatic logic exp_mapped(logic [2:0] m);
    return (m == 3'd0) || (m == 3'd2) || (m == 3'd4);
  endfunction

  function automatic logic [7:0] exp_claim(logic [7:0] c);
    return {c[7], c[5], c[5], ~c[4], c[3], c[2], 2'b00};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pins(string tag);
    logic [7:0] cl, sig, eo, ed;
    cl  = exp_claim(m_reg);
    sig = {noacc_i, pipe_i[1], pipe_i[0], eclk_i, lstrb_i, rw_i, 2'b00};
    eo  = cl | (~cl & ddr_i);
    ed  = (cl & sig) | (~cl & dat_i);
    #1;
    chk({tag, " oe"}, oe_o, eo);
    chk({tag, " do"}, do_o, ed);
  endtask

  task automatic rand_pins();
    ddr_i   = 8'($urandom);
    dat_i   = 8'($urandom);
    eclk_i  = 1'($urandom);
    rw_i    = 1'($urandom);
    lstrb_i = 1'($urandom);
    pipe_i  = 2'($urandom);
    noacc_i = 1'($urandom);
  endtask

  task automatic do_reset(logic [2:0] m);
    @(posedge clk_i); #1;
    mode_i = m;
    rst_ni = 1'b0;
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    m_mode = m;
    m_reg  = exp_reset(m);
  endtask

  task automatic do_read(string tag);
    @(posedge clk_i); #1;
    sel_i = 1'b1; wr_i = 1'b0;
    #1;
    chk({tag, " rd"}, rdata_o, exp_mapped(m_mode) ? m_reg : 8'h00);
    chk({tag, " ext"}, {7'd0, ext_o}, {7'd0, ~exp_mapped(m_mode)});
    sel_i = 1'b0;
  endtask

  task automatic do_write(logic [7:0] v);
    @(posedge clk_i); #1;
    sel_i = 1'b1; wr_i = 1'b1; wdata_i = v;
    @(posedge clk_i); #1;
    sel_i = 1'b0; wr_i = 1'b0;
    if (exp_mapped(m_mode)) m_reg = v & 8'hBC;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // reset image in every mode, ddr cleared so claimed pins stand out
    for (int m = 0; m < 8; m++) begin
      do_reset(3'(m));
      ddr_i = '0; dat_i = '0;
      chk_pins("R1 R2 R3 R4 reset");
      do_read("R1 R7 R8 reset");
    end
    // R5 claimed pins ignore ddr, R6 low pins follow ddr
    do_reset(3'd2);
    for (int k = 0; k < 16; k++) begin
      @(posedge clk_i); #1; rand_pins();
      chk_pins("R5 R6 test mode");
    end
    // R5 bus clock polarity both ways, R7 next-cycle effect
    do_write(8'h10); rand_pins(); chk_pins("R5 R7 eclk off");
    do_read("R7 eclk off");
    do_write(8'h80); rand_pins(); chk_pins("R5 R7 noacc on");
    // R10 reserved bits
    do_write(8'hFF); do_read("R10 all ones");
    do_write(8'h43); do_read("R10 reserved only");
    // R8 unmapped write in normal expanded
    do_reset(3'd5);
    do_write(8'hBC); rand_pins(); chk_pins("R8 unmapped write");
    do_read("R8 unmapped read");
    // R9 strap change without reset
    do_reset(3'd4);
    @(posedge clk_i); #1; mode_i = 3'd3;
    @(posedge clk_i); #1; rand_pins(); chk_pins("R9 strap moved");
    do_read("R9 mapping kept");
    do_write(8'h2C); rand_pins(); chk_pins("R9 write still lands");
    do_reset(3'd6);
    @(posedge clk_i); #1; mode_i = 3'd0;
    do_write(8'hA4); do_read("R9 periph stays hidden");
    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0) do_reset(3'($urandom));
      else if (op < 4) do_write(8'($urandom));
      else if (op < 6) do_read("R7 R8 random");
      else if (op == 6) begin @(posedge clk_i); #1; mode_i = 3'($urandom); end
      @(posedge clk_i); #1; rand_pins();
      chk_pins("R5 R6 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule